// File: doc/BRIEF.md
# Receive FIFO Watermark Pause Generator

This block watches the fill level of a receive FIFO and asks a transmit frame builder to send flow-control PAUSE frames. When occupancy reaches a high watermark, it issues a pause-on request that carries a programmable quanta value. It then holds that pause until occupancy drains below a separate low watermark. At that point it issues a pause-off request with zero quanta. Because the two thresholds differ, the block cannot produce a burst of on/off requests while the level hovers around one value.

While the pause is held, a refresh timer counts pause-quantum ticks supplied from the MAC timing logic. If occupancy is still at or above the low watermark once half of the requested pause time has passed, the pause-on request is sent again. This keeps the link partner quiet until the FIFO has really drained. Flow control only works on a full-duplex link with pause support switched on. If either condition is removed while a pause is held, the block releases the partner with a pause-off request.

The watermarks count FIFO entries, not bytes. They reset to a quarter and an eighth of the FIFO depth, and the quanta resets to its maximum. A simple write port can change all three. Each request is a single-cycle pulse with its quanta value alongside.

Top module: `pfc_watermark_pause`

## Requirements
- R1: After reset, the high watermark is DEPTH/4 entries (64 by default), the low watermark is DEPTH/8 (32), the quanta is 0xFFFF, no pause is held and no request is pending.
- R2: A write with `cfg_wr` high uses `cfg_sel` to pick the register: 0 is the high watermark, 1 the low watermark and 2 the quanta. Watermarks take the low bits of `cfg_wdata`. The new value is used from the cycle after the write.
- R3: Requests are produced only while both `full_duplex` and `pause_en` are high. While not holding a pause and disabled, no request is issued. A level already at or above the high watermark when enabling returns triggers a pause-on request.
- R4: While not holding, an enabled block seeing `fill_level` >= high watermark raises `pause_req` for one cycle, with `pause_quanta` equal to the quanta register, in the cycle after the sampling edge. It then sets `pause_held`.
- R5: While held, occupancy staying at or above the low watermark produces no further request until the refresh timer expires.
- R6: While held, `fill_level` < low watermark raises a one-cycle request with quanta 0 and clears `pause_held`. Levels from the low watermark up to just below the high watermark never start a pause.
- R7: Every pause-on request (re)loads a timer with quanta/2 (integer division). A tick on `quanta_tick` when the timer is at 1 or 0 re-issues the pause-on request and reloads the timer. A tick otherwise decrements the timer. A quanta of 0 or 1 therefore re-issues on the first tick.
- R8: When a refresh expiry and a drop below the low watermark happen in the same cycle, only the pause-off request is issued. Ticks after the release produce nothing.
- R9: Removing `full_duplex` or `pause_en` while holding a pause produces a pause-off request (quanta 0) and clears `pause_held`. A pause-off request is never produced without a preceding pause-on.
- R10: A write with `cfg_sel` = 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Link is full duplex |
| pause_en | input | 1 | Pause flow control negotiated and allowed |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 high mark, 1 low mark, 2 quanta, 3 none |
| cfg_wdata | input | 16 | Configuration write data |
| fill_level | input | $clog2(DEPTH+1) | Receive FIFO occupancy in entries |
| quanta_tick | input | 1 | One pulse per elapsed pause quantum |
| pause_req | output | 1 | One-cycle request to the transmit frame builder |
| pause_quanta | output | 16 | Quanta to place in the requested frame, valid with pause_req |
| pause_held | output | 1 | A pause-on is outstanding |

## Verification
Each request is due exactly one cycle after the clock edge that samples the stimulus causing it. This applies to a crossing, a drain, an enable change or a tick. `pause_held` changes on that same edge. A configuration write is registered on its edge and affects decisions from the following edge. The bench drives inputs two nanoseconds after a rising edge and records each expected request with the cycle number it is due in. A monitor at every falling edge matches requests against that queue by cycle and quanta. It reports any request that arrives early, late or unannounced, so quiet windows are checked as strictly as the requests themselves.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int QUANTA_W = 16;

    typedef enum logic [1:0] {
        SEL_HIGH   = 2'd0,
        SEL_LOW    = 2'd1,
        SEL_QUANTA = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/pfc_cfg_regs.sv
module pfc_cfg_regs
    import pfc_pkg::*;
#(
    parameter int LVL_W    = 9,
    parameter int HIGH_RST = 64,
    parameter int LOW_RST  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [1:0]          cfg_sel,
    input  logic [QUANTA_W-1:0] cfg_wdata,
    output logic [LVL_W-1:0]    high_mark,
    output logic [LVL_W-1:0]    low_mark,
    output logic [QUANTA_W-1:0] quanta
);

    typedef struct packed {
        logic [LVL_W-1:0]    high;
        logic [LVL_W-1:0]    low;
        logic [QUANTA_W-1:0] quanta;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        high:   LVL_W'(HIGH_RST),
        low:    LVL_W'(LOW_RST),
        quanta: {QUANTA_W{1'b1}}
    };

    cfg_t cfg_d, cfg_q;
    logic [LVL_W-1:0] wr_level;

    // Watermark write value: truncate or zero-extend the data bus
    generate
        if (LVL_W <= QUANTA_W) begin : g_trunc
            assign wr_level = cfg_wdata[LVL_W-1:0];
        end else begin : g_extend
            assign wr_level = {{(LVL_W-QUANTA_W){1'b0}}, cfg_wdata};
        end
    endgenerate

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_HIGH:   cfg_d.high   = wr_level;
                SEL_LOW:    cfg_d.low    = wr_level;
                SEL_QUANTA: cfg_d.quanta = cfg_wdata;
                default:    cfg_d        = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign high_mark = cfg_q.high;
    assign low_mark  = cfg_q.low;
    assign quanta    = cfg_q.quanta;

    // R2: a high watermark write is visible on the next cycle
    a_r2_high_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_HIGH) |=> (high_mark == $past(wr_level)));

    // R2: a quanta write is visible on the next cycle
    a_r2_quanta_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_QUANTA) |=> (quanta == $past(cfg_wdata)));

    // R10: the unused select leaves every register untouched
    a_r10_none_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel == SEL_NONE) |=> $stable(cfg_q));

endmodule

// File: rtl/pfc_refresh_timer.sv
module pfc_refresh_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_step;

    // The count has reached its final quantum
    assign last_step = (tmr_q.cnt <= CNT_W'(1));
    assign expire    = tick && tmr_q.armed && last_step;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end else if (load) begin
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = load_val;
        end else if (tick && tmr_q.armed && !last_step) begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: an armed timer steps down by one per tick until it expires
    a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.armed && tick && !load && !clear && !last_step)
            |=> (tmr_q.cnt == $past(tmr_q.cnt) - CNT_W'(1)));

    // R8: a release disarms the timer so later ticks cannot fire
    a_r8_clear_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tmr_q.armed);

endmodule

// File: rtl/pfc_hold_fsm.sv
module pfc_hold_fsm
    import pfc_pkg::*;
#(
    parameter int LVL_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LVL_W-1:0]    fill,
    input  logic [LVL_W-1:0]    high_mark,
    input  logic [LVL_W-1:0]    low_mark,
    input  logic [QUANTA_W-1:0] quanta,
    input  logic                enable,
    input  logic                expire,
    output logic                timer_load,
    output logic                timer_clear,
    output logic                req_valid,
    output logic [QUANTA_W-1:0] req_quanta,
    output logic                paused
);

    typedef struct packed {
        hold_state_e         st;
        logic                req_valid;
        logic [QUANTA_W-1:0] req_quanta;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic at_high, below_low;

    assign at_high   = (fill >= high_mark);
    assign below_low = (fill < low_mark);

    always_comb begin
        fsm_d            = fsm_q;
        fsm_d.req_valid  = 1'b0;
        fsm_d.req_quanta = '0;
        timer_load       = 1'b0;
        timer_clear      = 1'b0;
        case (fsm_q.st)
            ST_OPEN: begin
                if (enable && at_high) begin
                    fsm_d.st         = ST_HOLD;
                    fsm_d.req_valid  = 1'b1;
                    fsm_d.req_quanta = quanta;
                    timer_load       = 1'b1;
                end
            end
            ST_HOLD: begin
                if (!enable || below_low) begin
                    // Release takes precedence over a refresh
                    fsm_d.st         = ST_OPEN;
                    fsm_d.req_valid  = 1'b1;
                    fsm_d.req_quanta = '0;
                    timer_clear      = 1'b1;
                end else if (expire) begin
                    fsm_d.req_valid  = 1'b1;
                    fsm_d.req_quanta = quanta;
                    timer_load       = 1'b1;
                end
            end
            default: fsm_d.st = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fsm_q <= '{st: ST_OPEN, req_valid: 1'b0, req_quanta: '0};
        else        fsm_q <= fsm_d;
    end

    assign req_valid  = fsm_q.req_valid;
    assign req_quanta = fsm_q.req_quanta;
    assign paused     = (fsm_q.st == ST_HOLD);

    // R4: entering the hold state comes with a request carrying the quanta
    a_r4_on_enters_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> (req_valid && req_quanta == $past(quanta)));

    // R6: leaving the hold state comes with a zero-quanta request
    a_r6_off_leaves_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(paused) |-> (req_valid && req_quanta == '0));

    // R3: a disabled block with nothing held stays silent
    a_r3_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !paused) |=> !req_valid);

    // R5: a held pause with no expiry and no drain issues nothing
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && enable && !below_low && !expire) |=> (!req_valid && paused));

endmodule

// File: rtl/pfc_watermark_pause.sv
module pfc_watermark_pause
    import pfc_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       full_duplex,
    input  logic                       pause_en,
    input  logic                       cfg_wr,
    input  logic [1:0]                 cfg_sel,
    input  logic [QUANTA_W-1:0]        cfg_wdata,
    input  logic [$clog2(DEPTH+1)-1:0] fill_level,
    input  logic                       quanta_tick,
    output logic                       pause_req,
    output logic [QUANTA_W-1:0]        pause_quanta,
    output logic                       pause_held
);

    localparam int LVL_W    = $clog2(DEPTH + 1);
    localparam int HIGH_RST = DEPTH / 4;
    localparam int LOW_RST  = DEPTH / 8;
    localparam int CNT_W    = QUANTA_W - 1;

    logic [LVL_W-1:0]    high_mark;
    logic [LVL_W-1:0]    low_mark;
    logic [QUANTA_W-1:0] quanta;
    logic                enable;
    logic                expire;
    logic                timer_load;
    logic                timer_clear;

    assign enable = full_duplex && pause_en;

    pfc_cfg_regs #(
        .LVL_W    (LVL_W),
        .HIGH_RST (HIGH_RST),
        .LOW_RST  (LOW_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .high_mark (high_mark),
        .low_mark  (low_mark),
        .quanta    (quanta)
    );

    pfc_refresh_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .clear    (timer_clear),
        .tick     (quanta_tick),
        .load_val (quanta[QUANTA_W-1:1]),
        .expire   (expire)
    );

    pfc_hold_fsm #(
        .LVL_W (LVL_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill        (fill_level),
        .high_mark   (high_mark),
        .low_mark    (low_mark),
        .quanta      (quanta),
        .enable      (enable),
        .expire      (expire),
        .timer_load  (timer_load),
        .timer_clear (timer_clear),
        .req_valid   (pause_req),
        .req_quanta  (pause_quanta),
        .paused      (pause_held)
    );

    // R9: dropping either enable while held releases the partner
    a_r9_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_held && !enable) |=> (pause_req && pause_quanta == '0 && !pause_held));

endmodule

// File: tb/tb_pfc_watermark_pause.sv
module tb_pfc_watermark_pause;

    localparam int DEPTH = 256;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             full_duplex = 1'b1;
    logic             pause_en = 1'b1;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [15:0]      cfg_wdata = 16'd0;
    logic [LVL_W-1:0] fill_level = '0;
    logic             quanta_tick = 1'b0;
    logic             pause_req;
    logic [15:0]      pause_quanta;
    logic             pause_held;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int    exp_due[$];
    int    exp_qnt[$];
    string exp_tag[$];

    pfc_watermark_pause #(.DEPTH(DEPTH)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .full_duplex  (full_duplex),
        .pause_en     (pause_en),
        .cfg_wr       (cfg_wr),
        .cfg_sel      (cfg_sel),
        .cfg_wdata    (cfg_wdata),
        .fill_level   (fill_level),
        .quanta_tick  (quanta_tick),
        .pause_req    (pause_req),
        .pause_quanta (pause_quanta),
        .pause_held   (pause_held)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary_and_end();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver side: the stimulus just applied yields a request next cycle
    task automatic expect_req(int qnt, string tag);
        exp_due.push_back(cyc + 1);
        exp_qnt.push_back(qnt);
        exp_tag.push_back(tag);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic quiet(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_cfg(logic [1:0] sel, logic [15:0] data);
        cfg_wr    = 1'b1;
        cfg_sel   = sel;
        cfg_wdata = data;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic tick_once();
        quanta_tick = 1'b1;
        step();
        quanta_tick = 1'b0;
        step();
    endtask

    task automatic check_held(logic exp, string tag);
        checks++;
        if (pause_held !== exp) begin
            failures++;
            $display("FAIL %s: pause_held actual=%0b expected=%0b", tag, pause_held, exp);
        end
    endtask

    // Monitor side: scoreboard against the expectation queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_due.size() > 0 && exp_due[0] < cyc) begin
                checks++;
                failures++;
                $display("FAIL %s: request due in cycle %0d, actual none, expected quanta=%0d",
                         exp_tag[0], exp_due[0], exp_qnt[0]);
                void'(exp_due.pop_front());
                void'(exp_qnt.pop_front());
                void'(exp_tag.pop_front());
            end
            if (pause_req) begin
                checks++;
                if (exp_due.size() == 0 || exp_due[0] != cyc) begin
                    failures++;
                    $display("FAIL unexpected request (R3 R5 R8 R10) in cycle %0d: actual quanta=%0d, expected none",
                             cyc, pause_quanta);
                end else begin
                    if (pause_quanta !== exp_qnt[0][15:0]) begin
                        failures++;
                        $display("FAIL %s: quanta actual=%0d expected=%0d",
                                 exp_tag[0], pause_quanta, exp_qnt[0]);
                    end
                    void'(exp_due.pop_front());
                    void'(exp_qnt.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, actual hang, expected completion");
        summary_and_end();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        step();
        check_held(1'b0, "R1 reset state");

        // R1 / R4: default high watermark of 64 and default quanta
        fill_level = 9'd63;
        quiet(3);
        fill_level = 9'd64;
        expect_req(16'hFFFF, "R1 R4 default crossing");
        step();
        check_held(1'b1, "R4 held after on");

        // R5: staying high does not repeat
        fill_level = 9'd200;
        quiet(5);
        fill_level = 9'd40;
        quiet(2);
        fill_level = 9'd32;
        quiet(2);
        check_held(1'b1, "R5 still held at low mark");

        // R6 / R1: default low watermark of 32
        fill_level = 9'd31;
        expect_req(0, "R6 R1 drain below low");
        step();
        check_held(1'b0, "R6 released");
        fill_level = 9'd40;
        quiet(3);
        check_held(1'b0, "R6 hysteresis band");

        // R10: select 3 changes nothing
        fill_level = 9'd0;
        write_cfg(2'd3, 16'd5);
        fill_level = 9'd63;
        quiet(3);
        check_held(1'b0, "R10 ignored write");

        // R2: program high=10, low=4, quanta=8
        fill_level = 9'd0;
        write_cfg(2'd0, 16'd10);
        write_cfg(2'd1, 16'd4);
        write_cfg(2'd2, 16'd8);
        fill_level = 9'd9;
        quiet(2);
        fill_level = 9'd10;
        expect_req(8, "R2 programmed crossing");
        step();
        check_held(1'b1, "R2 held");

        // R7: refresh after quanta/2 = 4 ticks, then again after reload
        for (int i = 0; i < 3; i++) tick_once();
        quanta_tick = 1'b1;
        expect_req(8, "R7 first refresh");
        step();
        quanta_tick = 1'b0;
        step();
        for (int i = 0; i < 3; i++) tick_once();
        quanta_tick = 1'b1;
        expect_req(8, "R7 second refresh");
        step();
        quanta_tick = 1'b0;
        step();

        // R8: expiry and drain in the same cycle
        for (int i = 0; i < 3; i++) tick_once();
        fill_level  = 9'd3;
        quanta_tick = 1'b1;
        expect_req(0, "R8 release wins");
        step();
        quanta_tick = 1'b0;
        step();
        check_held(1'b0, "R8 released");
        tick_once();
        tick_once();

        // R9: dropping pause_en while held
        fill_level = 9'd12;
        expect_req(8, "R9 setup on");
        step();
        pause_en = 1'b0;
        expect_req(0, "R9 disable releases");
        step();
        check_held(1'b0, "R9 released");
        quiet(3);

        // R3: half duplex blocks, re-enable with a high level triggers
        pause_en    = 1'b1;
        full_duplex = 1'b0;
        quiet(3);
        check_held(1'b0, "R3 half duplex quiet");
        full_duplex = 1'b1;
        expect_req(8, "R3 re-enable at high level");
        step();
        check_held(1'b1, "R3 held");

        // R7: quanta 1 refreshes on the first tick
        write_cfg(2'd2, 16'd1);
        fill_level = 9'd2;
        expect_req(0, "R6 drain");
        step();
        fill_level = 9'd12;
        expect_req(1, "R7 on with quanta 1");
        step();
        quanta_tick = 1'b1;
        expect_req(1, "R7 first-tick refresh");
        step();
        quanta_tick = 1'b0;
        quiet(3);

        checks++;
        if (exp_due.size() != 0) begin
            failures++;
            $display("FAIL R4 R6 R7: outstanding requests actual=%0d expected=0", exp_due.size());
        end
        summary_and_end();
    end

endmodule